// File: doc/BRIEF.md
# Filtered Quadrature Decoder Counter

This block turns two phase inputs from a rotary or linear encoder into count steps for a timer. Each phase first passes through its own optional polarity inversion and its own length filter. The filter lets a new level through only after the level has stayed unchanged for the programmed number of clock cycles. A programmed length of zero turns the filter into a plain one-cycle register. The filtered pair is then interpreted in one of two ways, chosen by a mode input.

In A/B mode (`mode_i = 0`), the decoder tracks the pair as one of four phase states, named PH_00, PH_01, PH_10 and PH_11 after {A,B}. A forward transition follows the order PH_00 → PH_10 → PH_11 → PH_01 → PH_00, which is the case where A leads B, and it counts up. The backward transition, the reverse of that order, counts down. A diagonal jump, where both bits change at once, is taken as the new state but gives no count. In count/direction mode (`mode_i = 1`), each rising edge of filtered A gives one count, and filtered B selects the direction: high means up, low means down.

Every count pulses `cnt_en_o` for one cycle, with `cnt_up_o` giving the direction. The count also steps an internal position counter that wraps between 0 and `modulo_i`. Each filter is a two-state machine: FS_STEADY moves to FS_SETTLE on a level difference and returns to FS_STEADY either on a match or when the length is reached.

Top module: `quad_decoder`

## Requirements
- R1: After reset, `pos_o` is 0 and `cnt_en_o` and `wrap_o` are low. `wrap_o` is never high unless a count step happened in the cycle before.
- R2: With a filter length L ≥ 1 on a phase, a level change that holds for L clock cycles is passed on, and a pulse shorter than L cycles is discarded. A change driven just before clock edge k produces `cnt_en_o` high after edge k+L.
- R3: A filter length of 0 bypasses the filter. The level is passed after one edge, and the count pulse follows after edge k+1.
- R4: `inv_a_i` and `inv_b_i` each invert their phase before filtering and decoding.
- R5: In A/B mode, each forward transition gives one count with `cnt_up_o = 1`, and `pos_o` increases by 1 when it is below `modulo_i`.
- R6: In A/B mode, each backward transition gives one count with `cnt_up_o = 0`, and `pos_o` decreases by 1 when it is not 0.
- R7: In A/B mode, a change of both phases in the same cycle gives no count.
- R8: In count/direction mode, a rising edge of A counts up if B is 1 and down if B is 0. A falling edge of A and any change of B give no count.
- R9: An up count at `pos_o >= modulo_i` sets `pos_o` to 0 and pulses `wrap_o` with `wrap_up_o = 1`.
- R10: A down count at `pos_o = 0` loads `modulo_i` and pulses `wrap_o` with `wrap_up_o = 0`.
- R11: `cnt_en_o` is high for exactly one cycle per count, and is never high without a qualifying transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = A/B quadrature, 1 = count/direction |
| inv_a_i | input | 1 | Invert phase A |
| inv_b_i | input | 1 | Invert phase B |
| flt_a_i | input | FLT_W | Filter length for phase A, 0 = bypass |
| flt_b_i | input | FLT_W | Filter length for phase B, 0 = bypass |
| modulo_i | input | CNT_W | Highest position value |
| pha_i | input | 1 | Phase A input |
| phb_i | input | 1 | Phase B input |
| cnt_en_o | output | 1 | One-cycle count pulse |
| cnt_up_o | output | 1 | Direction of the latest count, 1 = up |
| pos_o | output | CNT_W | Position counter |
| wrap_o | output | 1 | One-cycle wrap pulse |
| wrap_up_o | output | 1 | Direction of the latest wrap, 1 = up |

## Verification
The bench drives both phases across the modulo boundary in each direction. A counter that wrapped one step early or late, or that loaded 0 instead of the modulo value on a down wrap, would show up in both the position and the wrap direction. It also sends a diagonal A/B jump, falling A edges and changes on B alone in count/direction mode. A decoder that counted any of these would produce a pulse that the scoreboard never expected. Glitches shorter than the filter length, and the exact arrival cycle of every pulse, catch a filter that is off by one cycle or that leaks glitches through. Inverting each phase while holding its logical level shows whether the inversion is applied to the right phase.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    typedef enum logic {
        QD_MODE_AB = 1'b0,
        QD_MODE_CD = 1'b1
    } qd_mode_e;

    // encoded as {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } qd_phase_e;

    typedef enum logic {
        FS_STEADY = 1'b0,
        FS_SETTLE = 1'b1
    } flt_state_e;
endpackage

// File: rtl/qdec_glitch_filter.sv
module qdec_glitch_filter
    import qdec_pkg::*;
#(
    parameter int FLT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             raw_i,
    input  logic             inv_i,
    input  logic [FLT_W-1:0] len_i,
    output logic             lvl_o
);
    flt_state_e       state_q, state_d;
    logic [FLT_W-1:0] cnt_q;
    logic [FLT_W:0]   cnt_nx;
    logic             in_pol, diff, upd;

    assign in_pol = raw_i ^ inv_i;
    assign diff   = (in_pol != lvl_o);
    assign cnt_nx = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        state_d = state_q;
        upd     = 1'b0;
        unique case (state_q)
            FS_STEADY: begin
                if (diff) begin
                    if (len_i <= FLT_W'(1)) upd = 1'b1;
                    else                    state_d = FS_SETTLE;
                end
            end
            FS_SETTLE: begin
                if (!diff) begin
                    state_d = FS_STEADY;
                end else if (cnt_nx >= {1'b0, len_i}) begin
                    upd     = 1'b1;
                    state_d = FS_STEADY;
                end
            end
            default: state_d = FS_STEADY;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= FS_STEADY;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_o <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (upd) lvl_o <= in_pol;
            if (state_d == FS_SETTLE)
                cnt_q <= (state_q == FS_SETTLE) ? cnt_nx[FLT_W-1:0] : FLT_W'(1);
            else
                cnt_q <= '0;
        end
    end

    // R2: the filtered level only ever moves to a level seen at the input
    a_r2_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lvl_o) |-> (lvl_o == $past(in_pol)));

    // R3: zero length passes any difference on the next edge
    a_r3_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (len_i == '0 && diff) |=> (lvl_o == $past(in_pol)));
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
    import qdec_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_i,
    input  logic a_i,
    input  logic b_i,
    output logic step_o,
    output logic up_o
);
    qd_phase_e prv_q, cur;
    logic      fwd, rev, step_d, up_d, prv_a, prv_b;

    assign cur   = qd_phase_e'({a_i, b_i});
    assign prv_a = prv_q[1];
    assign prv_b = prv_q[0];

    // forward order 00 -> 10 -> 11 -> 01 -> 00 (A leads B)
    always_comb begin
        fwd = 1'b0;
        rev = 1'b0;
        unique case (prv_q)
            PH_00: begin fwd = (cur == PH_10); rev = (cur == PH_01); end
            PH_10: begin fwd = (cur == PH_11); rev = (cur == PH_00); end
            PH_11: begin fwd = (cur == PH_01); rev = (cur == PH_10); end
            PH_01: begin fwd = (cur == PH_00); rev = (cur == PH_11); end
            default: ;
        endcase
    end

    always_comb begin
        unique case (qd_mode_e'(mode_i))
            QD_MODE_AB: begin
                step_d = fwd | rev;
                up_d   = fwd;
            end
            QD_MODE_CD: begin
                step_d = !prv_a && a_i;
                up_d   = b_i;
            end
            default: begin
                step_d = 1'b0;
                up_d   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prv_q <= PH_00;
        else         prv_q <= cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            step_o <= 1'b0;
            up_o   <= 1'b0;
        end else begin
            step_o <= step_d;
            if (step_d) up_o <= up_d;
        end
    end

    // R7: a diagonal jump in A/B mode never yields a count
    a_r7_no_jump_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == QD_MODE_AB && a_i != prv_a && b_i != prv_b) |=> !step_o);

    // R8: a falling A edge in count/direction mode is silent
    a_r8_fall_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == QD_MODE_CD && prv_a && !a_i) |=> !step_o);
endmodule

// File: rtl/qdec_position.sv
module qdec_position #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             up_i,
    input  logic [CNT_W-1:0] mod_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             wrap_o,
    output logic             wrap_up_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_o     <= '0;
            wrap_o    <= 1'b0;
            wrap_up_o <= 1'b0;
        end else begin
            wrap_o <= 1'b0;
            if (step_i) begin
                if (up_i) begin
                    if (pos_o >= mod_i) begin
                        pos_o     <= '0;
                        wrap_o    <= 1'b1;
                        wrap_up_o <= 1'b1;
                    end else begin
                        pos_o <= pos_o + CNT_W'(1);
                    end
                end else begin
                    if (pos_o == '0) begin
                        pos_o     <= mod_i;
                        wrap_o    <= 1'b1;
                        wrap_up_o <= 1'b0;
                    end else begin
                        pos_o <= pos_o - CNT_W'(1);
                    end
                end
            end
        end
    end

    a_r1_wrap_needs_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> $past(step_i));
    a_r5_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && up_i && pos_o < mod_i) |=> (pos_o == $past(pos_o) + CNT_W'(1)));
    a_r6_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !up_i && pos_o != '0) |=> (pos_o == $past(pos_o) - CNT_W'(1)));
    a_r9_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && up_i && pos_o >= mod_i) |=> (pos_o == '0 && wrap_o && wrap_up_o));
    a_r10_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !up_i && pos_o == '0) |=> (pos_o == $past(mod_i) && wrap_o && !wrap_up_o));
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FLT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    input  logic [FLT_W-1:0] flt_a_i,
    input  logic [FLT_W-1:0] flt_b_i,
    input  logic [CNT_W-1:0] modulo_i,
    input  logic             pha_i,
    input  logic             phb_i,
    output logic             cnt_en_o,
    output logic             cnt_up_o,
    output logic [CNT_W-1:0] pos_o,
    output logic             wrap_o,
    output logic             wrap_up_o
);
    localparam int NPH = 2;

    logic             raw_v [NPH];
    logic             inv_v [NPH];
    logic [FLT_W-1:0] len_v [NPH];
    logic             lvl_v [NPH];

    assign raw_v[0] = pha_i;
    assign raw_v[1] = phb_i;
    assign inv_v[0] = inv_a_i;
    assign inv_v[1] = inv_b_i;
    assign len_v[0] = flt_a_i;
    assign len_v[1] = flt_b_i;

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        qdec_glitch_filter #(.FLT_W(FLT_W)) u_flt (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .raw_i (raw_v[g]),
            .inv_i (inv_v[g]),
            .len_i (len_v[g]),
            .lvl_o (lvl_v[g])
        );
    end

    qdec_decode u_dec (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .mode_i(mode_i),
        .a_i   (lvl_v[0]),
        .b_i   (lvl_v[1]),
        .step_o(cnt_en_o),
        .up_o  (cnt_up_o)
    );

    qdec_position #(.CNT_W(CNT_W)) u_pos (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (cnt_en_o),
        .up_i     (cnt_up_o),
        .mod_i    (modulo_i),
        .pos_o    (pos_o),
        .wrap_o   (wrap_o),
        .wrap_up_o(wrap_up_o)
    );
endmodule

// File: tb/quad_decoder_bench.sv
`timescale 1ns/1ps
module quad_decoder_bench;
    localparam int CW = 16;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
    logic [FW-1:0] flt_a = '0, flt_b = '0;
    logic [CW-1:0] modv = CW'(5);
    logic          pha = 1'b0, phb = 1'b0;
    logic          cnt_en_o, cnt_up_o, wrap_o, wrap_up_o;
    logic [CW-1:0] pos_o;

    always #2 clk = ~clk;

    quad_decoder #(.CNT_W(CW), .FLT_W(FW)) u_quad_decoder (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .inv_a_i(inv_a), .inv_b_i(inv_b),
        .flt_a_i(flt_a), .flt_b_i(flt_b), .modulo_i(modv), .pha_i(pha), .phb_i(phb),
        .cnt_en_o(cnt_en_o), .cnt_up_o(cnt_up_o), .pos_o(pos_o),
        .wrap_o(wrap_o), .wrap_up_o(wrap_up_o)
    );

    typedef struct {
        logic          up;
        int unsigned   t0;
        int unsigned   lat;
        logic [CW-1:0] pos;
        logic          wrap;
        logic          wrap_up;
        string         req;
        string         lreq;
    } exp_t;

    exp_t          q[$];
    exp_t          cur;
    bit            pend = 0;
    int unsigned   cyc = 0;
    int            tests = 0, fails = 0;
    bit            finished = 0;
    logic          la = 1'b0, lb = 1'b0;
    logic [CW-1:0] mpos = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: move logical phase levels, push the expected count if any
    task automatic move(input logic na, input logic nb, input int hold, input string req);
        exp_t e;
        logic ev, upd;
        int   l;
        @(negedge clk);
        ev  = 1'b0;
        upd = 1'b0;
        if (mode == 1'b0) begin
            if ((!la && !lb && na && !nb) || (la && !lb && na && nb) ||
                (la && lb && !na && nb) || (!la && lb && !na && !nb)) begin
                ev = 1'b1; upd = 1'b1;
            end else if ((!la && !lb && !na && nb) || (!la && lb && na && nb) ||
                         (la && lb && na && !nb) || (la && !lb && !na && !nb)) begin
                ev = 1'b1; upd = 1'b0;
            end
        end else begin
            ev  = !la && na;
            upd = nb;
        end
        l = (na != la) ? int'(flt_a) : int'(flt_b);
        e.lreq = (l > 1) ? "R2" : "R3";
        if (l < 1) l = 1;
        pha = na ^ inv_a;
        phb = nb ^ inv_b;
        if (ev) begin
            e.up = upd; e.t0 = cyc; e.lat = l + 1; e.req = req;
            e.wrap = 1'b0; e.wrap_up = 1'b0;
            if (upd) begin
                if (mpos >= modv) begin mpos = '0; e.wrap = 1'b1; e.wrap_up = 1'b1; e.req = "R9"; end
                else mpos = mpos + 1'b1;
            end else begin
                if (mpos == '0) begin mpos = modv; e.wrap = 1'b1; e.wrap_up = 1'b0; e.req = "R10"; end
                else mpos = mpos - 1'b1;
            end
            e.pos = mpos;
            q.push_back(e);
        end
        la = na;
        lb = nb;
        repeat (hold) @(negedge clk);
    endtask

    task automatic glitch_a(input int len);
        @(negedge clk); pha = ~pha;
        repeat (len) @(negedge clk);
        pha = ~pha;
        repeat (8) @(negedge clk);
    endtask

    task automatic glitch_b(input int len);
        @(negedge clk); phb = ~phb;
        repeat (len) @(negedge clk);
        phb = ~phb;
        repeat (8) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (pend) begin
                chk(pos_o == cur.pos, cur.req, "position", pos_o, cur.pos);
                chk(wrap_o == cur.wrap, cur.req, "wrap pulse", wrap_o, cur.wrap);
                if (cur.wrap) chk(wrap_up_o == cur.wrap_up, cur.req, "wrap direction", wrap_up_o, cur.wrap_up);
                chk(!cnt_en_o, "R11", "pulse width", cnt_en_o, 0);
                pend = 0;
            end else begin
                if (rst_n && wrap_o) chk(0, "R1", "wrap without step", 1, 0);
                if (rst_n && cnt_en_o) begin
                    if (q.size() == 0) chk(0, "R11", "unexpected count pulse", 1, 0);
                    else begin
                        cur = q.pop_front();
                        chk(cnt_up_o == cur.up, cur.req, "direction", cnt_up_o, cur.up);
                        chk(cyc - cur.t0 == cur.lat, cur.lreq, "latency", cyc - cur.t0, cur.lat);
                        pend = 1;
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pos_o == '0, "R1", "reset position", pos_o, 0);
        chk(!cnt_en_o && !wrap_o, "R1", "reset pulses", {cnt_en_o, wrap_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(pos_o == '0, "R1", "position after release", pos_o, 0);

        // R5 forward, crossing modulo (R9)
        move(1, 0, 6, "R5"); move(1, 1, 6, "R5"); move(0, 1, 6, "R5"); move(0, 0, 6, "R5");
        move(1, 0, 6, "R5"); move(1, 1, 6, "R5"); move(0, 1, 6, "R5");
        // R6 backward, crossing zero (R10)
        move(1, 1, 6, "R6"); move(1, 0, 6, "R6"); move(0, 0, 6, "R6");
        // R7 diagonal jump
        move(1, 1, 8, "R7");
        chk(pos_o == mpos, "R7", "position after jump", pos_o, mpos);
        move(0, 1, 6, "R5");

        // R4 inversion of A, logical level kept
        @(negedge clk); inv_a = 1'b1; pha = la ^ 1'b1;
        repeat (6) @(negedge clk);
        move(0, 0, 6, "R4"); move(1, 0, 6, "R4"); move(0, 0, 6, "R4");
        @(negedge clk); inv_b = 1'b1; phb = lb ^ 1'b1;
        repeat (6) @(negedge clk);
        move(0, 1, 6, "R4"); move(0, 0, 6, "R4");
        chk(pos_o == mpos, "R4", "position with inversion", pos_o, mpos);

        // R2 filters
        @(negedge clk); flt_a = FW'(3); flt_b = FW'(2);
        glitch_a(2);
        glitch_b(1);
        chk(pos_o == mpos, "R2", "glitches rejected", pos_o, mpos);
        move(1, 0, 8, "R2"); move(1, 1, 8, "R2"); move(0, 1, 8, "R2");
        @(negedge clk); flt_a = '0; flt_b = '0;

        // R8 count/direction
        @(negedge clk); mode = 1'b1;
        repeat (4) @(negedge clk);
        move(1, 1, 6, "R8");
        move(0, 1, 6, "R8");
        move(0, 0, 6, "R8");
        for (int i = 0; i < 7; i++) begin
            move(1, 0, 6, "R8");
            move(0, 0, 6, "R8");
        end
        move(0, 1, 6, "R8");
        for (int i = 0; i < 7; i++) begin
            move(1, 1, 6, "R8");
            move(0, 1, 6, "R8");
        end

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R11", "missing count pulses", q.size(), 0);
        chk(pos_o == mpos, "R5", "final position", pos_o, mpos);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule